// File: doc/BRIEF.md
# Two-Port GPIO Core with Input-Change Interrupt

This block holds the register state and pin logic for a pair of 8-bit bidirectional general-purpose ports. A bus interface in front of it (not part of this block) turns serial transactions into one-cycle write and read strobes that carry a register address. For every pin the core produces an output value and an output enable. Each pin is an input with its driver off, or an output driven from a stored bit. Input pins pass through a two-flop synchronizer. Reads of the input registers return those levels, optionally inverted per bit.

The interrupt is a level comparison, not an edge-latched flag. Each port keeps a snapshot of its synchronized pins, taken whenever that port's input register is read. The interrupt request is active while any input-configured pin differs from its snapshot bit. It drops when the pin goes back to the snapshot value, or when that port is read. The request is a pull-low enable for an open-drain line.

Top module: `gpio_port_core`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is all ones, every polarity bit is 0, both snapshots are all ones and `irq_pull` is 0.
- R2: A direction bit of 1 turns the pin's driver off (`pin_oe` bit 0). A direction bit of 0 enables the driver (`pin_oe` bit 1), and `pin_out` for that pin carries the output register bit. Pin b of port p is bit p*8+b of every pin vector.
- R3: The address is {kind[1:0], port}, where kind 0 = input, 1 = output, 2 = polarity and 3 = direction. Writes take effect at the strobe edge. A read returns the addressed register on `rd_data` in the cycle after `rd_en`. Writes to kind 0 change nothing.
- R4: An input read returns the synchronized pin level XOR the polarity bit, whatever the pin's direction.
- R5: An input read of a port sets that port's snapshot to the synchronized pin levels at the strobe edge.
- R6: `irq_pull` rises two clock edges after an input-configured pin moves away from its snapshot bit, and not after one edge.
- R7: `irq_pull` falls when the pin returns to its snapshot value, or at the edge of an input read of the pin's port.
- R8: Reading one port never clears a mismatch on the other port.
- R9: A pin configured as an output never raises `irq_pull`, whatever its level.
- R10: Changing a pin from output to input raises `irq_pull` at that write edge if the pin differs from the stored snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 3 | Write address {kind, port} |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | One-cycle register read strobe |
| rd_addr | input | 3 | Read address {kind, port} |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 16 | Pin levels as seen at the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin driver enables, 1 = drive |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
Some properties are checked on every cycle by the assertions. A write of the input kind leaves the stored registers untouched. A port's snapshot changes only on that port's read, and after the read it equals the synchronized pins from the strobe edge. A read with steady pins leaves that port with no mismatch. The interrupt never rises unless a pin or a register changed. The bench scenarios cover the rest: the reset values seen at the ports, the exact two-edge latency, and the polarity XOR on read data. They also show cross-port independence, the silence of output pins, and the interrupt that is raised on purpose when a pin changes from output to input.

// File: rtl/gpio_core_pkg.sv
// Package: shared register-kind encoding for the GPIO port core.
// Assumes the address layout {kind, port} used across the block.
package gpio_core_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_CFG = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// A chain of flops that brings asynchronous pin levels into the clock domain.
// Assumes the pins are quasi-static compared with the clock. The reset value
// matches the idle pull-up level.
module gpio_sync #(
    parameter int               WIDTH   = 16,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Purpose: each later flop resamples the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
// Module: gpio_port_slice
// Register and compare logic for one port: the output, polarity and
// direction registers, the snapshot taken on input reads, and the mismatch
// that feeds the interrupt. Assumes wr_en and rd_en are already qualified
// by the port field of the address.
module gpio_port_slice
    import gpio_core_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  reg_kind_e wr_kind,
    input  logic [W-1:0] wr_data,
    input  logic      rd_en,
    input  reg_kind_e rd_kind,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] out_q,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] rd_val,
    output logic      mismatch
);
    logic [W-1:0] pol_q;
    logic [W-1:0] snap_q;
    logic         capture;

    assign capture = rd_en && (rd_kind == KIND_IN);

    // Purpose: update the writable registers; an input-kind write is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else if (wr_en) begin
            case (wr_kind)
                KIND_OUT: out_q <= wr_data;
                KIND_POL: pol_q <= wr_data;
                KIND_CFG: cfg_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Purpose: take the snapshot of the synchronized pins on an input read.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '1;
        else if (capture) snap_q <= pin_sync;
    end

    // Purpose: select the value that a read of this port returns.
    always_comb begin
        case (rd_kind)
            KIND_IN:  rd_val = pin_sync ^ pol_q;
            KIND_OUT: rd_val = out_q;
            KIND_POL: rd_val = pol_q;
            default:  rd_val = cfg_q;
        endcase
    end

    // Purpose: flag any input-configured pin that differs from the snapshot.
    assign mismatch = |((pin_sync ^ snap_q) & cfg_q);

    AST_IN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q))); // R3
    AST_SNAP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snap_q == $past(pin_sync))); // R5
    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_q)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (!mismatch || (pin_sync != $past(pin_sync)))); // R7
endmodule

// File: rtl/gpio_port_core.sv
// Module: gpio_port_core
// Top of the two-port GPIO core. It decodes the {kind, port} address, builds
// one slice per port, registers the read data and combines the per-port
// mismatches into the pull-low interrupt request. Assumes one-cycle strobes
// from a bus front end.
module gpio_port_core
    import gpio_core_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W = KIND_W + PSEL_W,
    localparam int PINS   = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_pull
);
    logic [PINS-1:0]      pin_sync;
    logic [PORT_W-1:0]    slice_rd [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_mismatch;
    logic [PORT_W-1:0]    rd_mux;
    reg_kind_e            wr_kind;
    reg_kind_e            rd_kind;
    logic [PSEL_W-1:0]    wr_port;
    logic [PSEL_W-1:0]    rd_port;

    assign wr_kind = reg_kind_e'(wr_addr[ADDR_W-1 -: KIND_W]);
    assign rd_kind = reg_kind_e'(rd_addr[ADDR_W-1 -: KIND_W]);
    assign wr_port = wr_addr[PSEL_W-1:0];
    assign rd_port = rd_addr[PSEL_W-1:0];

    gpio_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PINS{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] out_q;
        logic [PORT_W-1:0] cfg_q;

        gpio_port_slice #(.W(PORT_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_port == PSEL_W'(p))),
            .wr_kind (wr_kind),
            .wr_data (wr_data),
            .rd_en   (rd_en && (rd_port == PSEL_W'(p))),
            .rd_kind (rd_kind),
            .pin_sync(pin_sync[p*PORT_W +: PORT_W]),
            .out_q   (out_q),
            .cfg_q   (cfg_q),
            .rd_val  (slice_rd[p]),
            .mismatch(port_mismatch[p])
        );

        assign pin_out[p*PORT_W +: PORT_W] = out_q;
        assign pin_oe[p*PORT_W +: PORT_W]  = ~cfg_q;
    end

    // Purpose: pick the addressed port's read value; an absent port reads zero.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PSEL_W'(p)) rd_mux = slice_rd[p];
        end
    end

    // Purpose: register read data so it is valid the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign irq_pull = |port_mismatch;

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pull && !wr_en) |=> (!$stable(pin_sync) || !irq_pull)); // R6
    AST_DRIVEN_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pull && !wr_en && $stable(pin_oe) && (pin_oe == '1)) |=> !irq_pull); // R9
endmodule

// File: tb/sim_gpio_port_core.sv
module sim_gpio_port_core;
    localparam int W = 8;
    localparam logic [1:0] K_IN = 2'd0, K_OUT = 2'd1, K_POL = 2'd2, K_CFG = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = 16'hFFFF;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq_pull;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_port_core u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pull(irq_pull)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] kind, input logic port, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = {kind, port}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] kind, input logic port, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = {kind, port};
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'hFFFF);
        check("R1 irq", {15'b0, irq_pull}, 16'h0);
        do_read(K_POL, 1'b0, d); check("R1 pol0", {8'h0, d}, 16'h0000);
        do_read(K_CFG, 1'b1, d); check("R1 cfg1", {8'h0, d}, 16'h00FF);
    endtask

    task automatic t_direction();
        do_write(K_CFG, 1'b0, 8'hF0);
        do_write(K_OUT, 1'b0, 8'hA5);
        check("R2 oe", pin_oe, 16'h000F);
        check("R2 out", pin_out, 16'hFFA5);
        do_write(K_CFG, 1'b0, 8'hFF);
        do_write(K_OUT, 1'b0, 8'hFF);
        check("R2 oe restored", pin_oe, 16'h0000);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_write(K_POL, 1'b1, 8'h3C);
        do_read(K_POL, 1'b1, d); check("R3 pol1 readback", {8'h0, d}, 16'h003C);
        do_write(K_IN, 1'b1, 8'h00);
        do_read(K_OUT, 1'b1, d); check("R3 in-write out1", {8'h0, d}, 16'h00FF);
        do_read(K_POL, 1'b1, d); check("R3 in-write pol1", {8'h0, d}, 16'h003C);
        do_read(K_CFG, 1'b1, d); check("R3 in-write cfg1", {8'h0, d}, 16'h00FF);
        check("R3 in-write pins", pin_oe, 16'h0000);
        do_write(K_POL, 1'b1, 8'h00);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        do_write(K_CFG, 1'b0, 8'h00);
        pin_in[7:0] = 8'h5A;
        settle();
        do_write(K_POL, 1'b0, 8'h0F);
        do_read(K_IN, 1'b0, d); check("R4 xor on output pins", {8'h0, d}, 16'h0055);
        do_write(K_CFG, 1'b0, 8'hFF);
        do_write(K_POL, 1'b0, 8'h00);
        do_read(K_IN, 1'b0, d); check("R4 plain read", {8'h0, d}, 16'h005A);
        check("R5 snapshot matches", {15'b0, irq_pull}, 16'h0);
        pin_in[7:0] = 8'hFF;
        settle();
        do_read(K_IN, 1'b0, d);
    endtask

    task automatic t_irq_basic();
        logic [7:0] d;
        pin_in[7:0] = 8'hF7;
        @(negedge clk); check("R6 one edge", {15'b0, irq_pull}, 16'h0);
        @(negedge clk); check("R6 two edges", {15'b0, irq_pull}, 16'h1);
        pin_in[7:0] = 8'hFF;
        settle(); check("R7 pin returns", {15'b0, irq_pull}, 16'h0);
        pin_in[7:0] = 8'hF7;
        settle(); check("R6 again", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b0, d);
        check("R5 read data", {8'h0, d}, 16'h00F7);
        check("R7 read clears", {15'b0, irq_pull}, 16'h0);
        pin_in[7:0] = 8'hFF;
        settle(); check("R5 new snapshot", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b0, d);
        check("R7 resync", {15'b0, irq_pull}, 16'h0);
    endtask

    task automatic t_port_indep();
        logic [7:0] d;
        pin_in = 16'h7FFE;
        settle(); check("R8 both set", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b1, d); check("R8 p1 read keeps p0", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b0, d); check("R8 p0 read clears", {15'b0, irq_pull}, 16'h0);
        pin_in = 16'hFFFF;
        settle();
        do_read(K_IN, 1'b0, d); check("R8 p0 read keeps p1", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b1, d); check("R8 p1 read clears", {15'b0, irq_pull}, 16'h0);
    endtask

    task automatic t_output_no_irq();
        logic [7:0] d;
        do_write(K_CFG, 1'b1, 8'h00);
        pin_in[15:8] = 8'h00;
        settle(); check("R9 outputs silent", {15'b0, irq_pull}, 16'h0);
        do_read(K_IN, 1'b1, d); check("R4 output pins read", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_switch();
        logic [7:0] d;
        pin_in[15:8] = 8'h10;
        settle(); check("R9 output toggle", {15'b0, irq_pull}, 16'h0);
        do_write(K_CFG, 1'b1, 8'hEF);
        check("R10 matching pins", {15'b0, irq_pull}, 16'h0);
        do_write(K_CFG, 1'b1, 8'hFF);
        check("R10 switch raises", {15'b0, irq_pull}, 16'h1);
        do_read(K_IN, 1'b1, d);
        check("R7 switch cleared", {15'b0, irq_pull}, 16'h0);
        pin_in[15:8] = 8'hFF;
        settle();
        do_read(K_IN, 1'b1, d);
        check("R7 final", {15'b0, irq_pull}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_regs();
        t_polarity();
        t_irq_basic();
        t_port_indep();
        t_output_no_irq();
        t_switch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule